// File: doc/BRIEF.md
# Pipelined Local Syndrome Predecoder

This block sits next to the syndrome readout of an error-correcting code and clears the simplest error chains before anything leaves the cold stage. Each cycle it may accept one window of syndrome flips. A window is a grid of `D` check positions by `R` measurement rounds. The window then passes through a fixed-depth pipeline. Three of the stages each pair flipped syndromes along one kind of edge:

- two adjacent checks in the same round;
- the same check in two consecutive rounds;
- a diagonal step, from check `d` in round `r` to check `d+1` in round `r+1`.

A matched pair is cleared from the window, and a bit is set in a correction bitmap that travels with the window. The bit marks the qubit or measurement-error location that lies between the two syndromes.

At the end of the pipeline the window is tested for leftover flips. If none remain, only the correction bitmap is meaningful and the residual output stays zero. If any flip remains, the window is flagged complex and its residual syndrome is forwarded for a heavier matcher downstream. A lone flip with no partner is never corrected here.

Top module: `syn_predecoder`

## Requirements
- R1: A synchronous active-high `rst` clears the valid bit of every pipeline stage. `res_valid` is 0 while reset is held and on the cycle after it. Any window that was in flight when reset was applied never appears at the output.
- R2: The pipeline has DEPTH=9 register stages and accepts one window per clock.
  - A window sampled with `win_valid`=1 at clock edge n appears with `res_valid`=1 after edge n+8.
  - A cycle with `win_valid`=0 produces a cycle with `res_valid`=0 at the same distance.
- R3: Same-round pairs. Syndrome bit index is `r*D+d`. Flips at (r,d) and (r,d+1) are cleared, and `res_fix` bit `r*(D-1)+d` is set.
- R4: Consecutive-round pairs. Flips at (r,d) and (r+1,d) are cleared, and `res_fix` bit `R*(D-1) + r*D + d` is set.
- R5: Diagonal pairs. Flips at (r,d) and (r+1,d+1) are cleared, and `res_fix` bit `R*(D-1) + (R-1)*D + r*(D-1) + d` is set.
- R6: Edge kinds are tried in a fixed order: same-round, then consecutive-round, then diagonal. A flip that a same-round pair consumes is no longer available to a later kind.
- R7: Within one edge kind, conflicting candidates are resolved by fixed priority: the lower check index wins, then the earlier round. For example, three adjacent flips in one round pair the lowest two and leave the third.
- R8: A syndrome bit joins at most one pair. Each pair removes exactly two flips.
- R9: A window with any flip left after all stages has `res_complex`=1. In particular, a single isolated flip is never corrected: its `res_fix` contribution is zero.
- R10: A window whose flips are all cleared has `res_complex`=0 and `res_syn` all zero.
- R11: When `res_complex`=1, `res_syn` equals the leftover flips, using the same bit indexing as `win_syn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | 1 | Window present this cycle |
| win_syn | input | R*D | Syndrome flips, bit r*D+d |
| res_valid | output | 1 | Processed window present |
| res_complex | output | 1 | Window has leftover flips |
| res_syn | output | R*D | Leftover flips (zero unless complex) |
| res_fix | output | R*(D-1)+(R-1)*D+(R-1)*(D-1) | Correction bitmap: same-round, consecutive-round and diagonal fields, in that order |

## Verification
The bench first sends every single-flip window, which tells apart a correct refusal to pair a lone flip from a spurious correction. It then sends every two-flip window, which covers each edge kind at every location, including the grid borders, and also every non-adjacent pair that must stay complex. Directed windows with three and four flips separate the stage ordering from the in-stage priority rules. Long streams of pseudo-random dense and sparse windows, with bubbles and a mid-stream reset, exercise the one-per-cycle flow and the latency against an arithmetic model of greedy pairing.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;

   typedef enum logic [1:0] {
      ST_PASS  = 2'd0,
      ST_SPACE = 2'd1,
      ST_TIME  = 2'd2,
      ST_DIAG  = 2'd3
   } stage_e;

   function automatic int sp_width(int d, int r);
      return r * (d - 1);
   endfunction

   function automatic int tm_width(int d, int r);
      return (r - 1) * d;
   endfunction

   function automatic int dg_width(int d, int r);
      return (r - 1) * (d - 1);
   endfunction

   function automatic int fix_width(int d, int r);
      return sp_width(d, r) + tm_width(d, r) + dg_width(d, r);
   endfunction

   // Fixed topology order of the matching stages.
   function automatic stage_e kind_of(int idx);
      case (idx)
         1:       return ST_SPACE;
         2:       return ST_TIME;
         3:       return ST_DIAG;
         default: return ST_PASS;
      endcase
   endfunction

endpackage

// File: rtl/pd_chain.sv
`timescale 1ns/1ps
// Greedy pairing along one chain of syndrome bits; lowest index has priority.
module pd_chain #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic [N-1:0] bits_in,
   output logic [N-1:0] bits_left,
   output logic [N-2:0] pairs
);

   generate
      if (N < 2) begin : g_bad_len
         $error("pd_chain: N must be at least 2");
      end
   endgenerate

   logic [N:0] padded;

   always_comb begin
      logic taken;
      taken = 1'b0;
      for (int i = 0; i < N - 1; i++) begin
         pairs[i] = bits_in[i] & bits_in[i+1] & ~taken;
         taken    = pairs[i];
      end
   end

   assign padded    = {1'b0, pairs, 1'b0};
   assign bits_left = bits_in & ~(padded[N-1:0] | padded[N:1]);

   // R8
   pair_overlap_chk: assert property (@(posedge clk) disable iff (rst)
      en |-> ((pairs & (pairs >> 1)) == '0));

   // R7
   leftover_gap_chk: assert property (@(posedge clk) disable iff (rst)
      en |-> ((bits_left & (bits_left >> 1)) == '0));

   // R8
   pair_count_chk: assert property (@(posedge clk) disable iff (rst)
      en |-> ($countones(bits_in) == $countones(bits_left) + 2 * $countones(pairs)));

endmodule

// File: rtl/pd_stage.sv
`timescale 1ns/1ps
// One pipeline register stage; KIND picks which edge type it pairs.
module pd_stage #(
   parameter int             D    = 8,
   parameter int             R    = 3,
   parameter pd_pkg::stage_e KIND = pd_pkg::ST_PASS,
   localparam int NB     = D * R,
   localparam int SPW    = pd_pkg::sp_width(D, R),
   localparam int TMW    = pd_pkg::tm_width(D, R),
   localparam int DGW    = pd_pkg::dg_width(D, R),
   localparam int FW     = SPW + TMW + DGW,
   localparam int TM_OFF = SPW,
   localparam int DG_OFF = SPW + TMW
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          v_in,
   input  logic [NB-1:0] syn_in,
   input  logic [FW-1:0] fix_in,
   output logic          v_q,
   output logic [NB-1:0] syn_q,
   output logic [FW-1:0] fix_q
);

   logic [NB-1:0] syn_nx;
   logic [FW-1:0] fix_nx;

   generate
      if (KIND == pd_pkg::ST_SPACE) begin : g_space
         logic [SPW-1:0] sp_add;
         for (genvar r = 0; r < R; r++) begin : g_row
            pd_chain #(.N(D)) u_chain (
               .clk       (clk),
               .rst       (rst),
               .en        (v_in),
               .bits_in   (syn_in[r*D +: D]),
               .bits_left (syn_nx[r*D +: D]),
               .pairs     (sp_add[r*(D-1) +: D-1])
            );
         end
         assign fix_nx = fix_in | FW'(sp_add);
      end else if (KIND == pd_pkg::ST_TIME) begin : g_time
         logic [TMW-1:0] tm_add;
         for (genvar d = 0; d < D; d++) begin : g_col
            logic [R-1:0] col_in;
            logic [R-1:0] col_left;
            logic [R-2:0] col_pairs;
            for (genvar r = 0; r < R; r++) begin : g_map
               assign col_in[r]      = syn_in[r*D + d];
               assign syn_nx[r*D + d] = col_left[r];
            end
            for (genvar r = 0; r < R - 1; r++) begin : g_fix
               assign tm_add[r*D + d] = col_pairs[r];
            end
            pd_chain #(.N(R)) u_chain (
               .clk       (clk),
               .rst       (rst),
               .en        (v_in),
               .bits_in   (col_in),
               .bits_left (col_left),
               .pairs     (col_pairs)
            );
         end
         assign fix_nx = fix_in | (FW'(tm_add) << TM_OFF);
      end else if (KIND == pd_pkg::ST_DIAG) begin : g_diag
         logic [DGW-1:0] dg_add;
         for (genvar g = 0; g < D + R - 1; g++) begin : g_line
            localparam int R0  = (g < D) ? 0 : g - D + 1;
            localparam int D0  = (g < D) ? g : 0;
            localparam int LEN = ((R - R0) < (D - D0)) ? (R - R0) : (D - D0);
            if (LEN < 2) begin : g_single
               assign syn_nx[R0*D + D0] = syn_in[R0*D + D0];
            end else begin : g_pair
               logic [LEN-1:0] ln_in;
               logic [LEN-1:0] ln_left;
               logic [LEN-2:0] ln_pairs;
               for (genvar j = 0; j < LEN; j++) begin : g_map
                  assign ln_in[j] = syn_in[(R0+j)*D + D0 + j];
                  assign syn_nx[(R0+j)*D + D0 + j] = ln_left[j];
               end
               for (genvar j = 0; j < LEN - 1; j++) begin : g_fix
                  assign dg_add[(R0+j)*(D-1) + D0 + j] = ln_pairs[j];
               end
               pd_chain #(.N(LEN)) u_chain (
                  .clk       (clk),
                  .rst       (rst),
                  .en        (v_in),
                  .bits_in   (ln_in),
                  .bits_left (ln_left),
                  .pairs     (ln_pairs)
               );
            end
         end
         assign fix_nx = fix_in | (FW'(dg_add) << DG_OFF);
      end else begin : g_pass
         assign syn_nx = syn_in;
         assign fix_nx = fix_in;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) v_q <= 1'b0;
      else     v_q <= v_in;
   end

   always_ff @(posedge clk) begin
      syn_q <= syn_nx;
      fix_q <= fix_nx;
   end

   // R2
   valid_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (v_q == $past(v_in)));

   // R3
   fix_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && v_q) |-> ((fix_q & $past(fix_in)) == $past(fix_in)));

endmodule

// File: rtl/pd_emit.sv
`timescale 1ns/1ps
// Final stage: decides complex vs clean and gates the residual.
module pd_emit #(
   parameter int NB = 24,
   parameter int FW = 51
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          v_in,
   input  logic [NB-1:0] syn_in,
   input  logic [FW-1:0] fix_in,
   output logic          res_valid,
   output logic          res_complex,
   output logic [NB-1:0] res_syn,
   output logic [FW-1:0] res_fix
);

   logic leftover;
   assign leftover = |syn_in;

   always_ff @(posedge clk) begin
      if (rst) begin
         res_valid   <= 1'b0;
         res_complex <= 1'b0;
      end else begin
         res_valid   <= v_in;
         res_complex <= v_in & leftover;
      end
   end

   always_ff @(posedge clk) begin
      res_syn <= leftover ? syn_in : '0;
      res_fix <= fix_in;
   end

   // R9
   complex_valid_chk: assert property (@(posedge clk) disable iff (rst)
      res_complex |-> res_valid);

   // R10
   quiet_window_chk: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !res_complex) |-> (res_syn == '0));

   // R11
   forward_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && res_complex) |-> (res_syn == $past(syn_in)));

endmodule

// File: rtl/syn_predecoder.sv
`timescale 1ns/1ps
module syn_predecoder #(
   parameter int D     = 8,
   parameter int R     = 3,
   parameter int DEPTH = 9,
   localparam int NB = D * R,
   localparam int FW = pd_pkg::fix_width(D, R),
   localparam int NS = DEPTH - 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          win_valid,
   input  logic [NB-1:0] win_syn,
   output logic          res_valid,
   output logic          res_complex,
   output logic [NB-1:0] res_syn,
   output logic [FW-1:0] res_fix
);

   generate
      if (D < 2)     begin : g_bad_d   $error("syn_predecoder: D must be at least 2"); end
      if (R < 2)     begin : g_bad_r   $error("syn_predecoder: R must be at least 2"); end
      if (DEPTH < 5) begin : g_bad_dep $error("syn_predecoder: DEPTH must be at least 5"); end
   endgenerate

   logic          v_s   [NS];
   logic [NB-1:0] syn_s [NS];
   logic [FW-1:0] fix_s [NS];

   generate
      for (genvar i = 0; i < NS; i++) begin : g_stage
         logic          v_i;
         logic [NB-1:0] syn_i;
         logic [FW-1:0] fix_i;
         if (i == 0) begin : g_head
            assign v_i   = win_valid;
            assign syn_i = win_syn;
            assign fix_i = '0;
         end else begin : g_link
            assign v_i   = v_s[i-1];
            assign syn_i = syn_s[i-1];
            assign fix_i = fix_s[i-1];
         end
         pd_stage #(
            .D    (D),
            .R    (R),
            .KIND (pd_pkg::kind_of(i))
         ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .v_in   (v_i),
            .syn_in (syn_i),
            .fix_in (fix_i),
            .v_q    (v_s[i]),
            .syn_q  (syn_s[i]),
            .fix_q  (fix_s[i])
         );
      end
   endgenerate

   pd_emit #(.NB(NB), .FW(FW)) u_emit (
      .clk         (clk),
      .rst         (rst),
      .v_in        (v_s[NS-1]),
      .syn_in      (syn_s[NS-1]),
      .fix_in      (fix_s[NS-1]),
      .res_valid   (res_valid),
      .res_complex (res_complex),
      .res_syn     (res_syn),
      .res_fix     (res_fix)
   );

endmodule

// File: tb/syn_predecoder_tb.sv
`timescale 1ns/1ps
module syn_predecoder_tb;

   localparam int D      = 8;
   localparam int R      = 3;
   localparam int DEPTH  = 9;
   localparam int NB     = D * R;
   localparam int SPW    = R * (D - 1);
   localparam int TMW    = (R - 1) * D;
   localparam int DGW    = (R - 1) * (D - 1);
   localparam int FW     = SPW + TMW + DGW;
   localparam int TM_OFF = SPW;
   localparam int DG_OFF = SPW + TMW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          win_valid = 1'b0;
   logic [NB-1:0] win_syn = '0;
   logic          res_valid;
   logic          res_complex;
   logic [NB-1:0] res_syn;
   logic [FW-1:0] res_fix;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   syn_predecoder #(.D(D), .R(R), .DEPTH(DEPTH)) u_dut (
      .clk         (clk),
      .rst         (rst),
      .win_valid   (win_valid),
      .win_syn     (win_syn),
      .res_valid   (res_valid),
      .res_complex (res_complex),
      .res_syn     (res_syn),
      .res_fix     (res_fix)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // Greedy pairing per requirements: same-round, then consecutive-round, then diagonal,
   // each scanned from lowest check index and earliest round.
   function automatic void model(input logic [NB-1:0] s, output logic [FW-1:0] f, output logic [NB-1:0] left);
      logic [NB-1:0] w;
      w = s;
      f = '0;
      for (int r = 0; r < R; r++)
         for (int d = 0; d < D - 1; d++)
            if (w[r*D+d] && w[r*D+d+1]) begin
               w[r*D+d] = 1'b0; w[r*D+d+1] = 1'b0;
               f[r*(D-1)+d] = 1'b1;
            end
      for (int d = 0; d < D; d++)
         for (int r = 0; r < R - 1; r++)
            if (w[r*D+d] && w[(r+1)*D+d]) begin
               w[r*D+d] = 1'b0; w[(r+1)*D+d] = 1'b0;
               f[TM_OFF + r*D + d] = 1'b1;
            end
      for (int r = 0; r < R - 1; r++)
         for (int d = 0; d < D - 1; d++)
            if (w[r*D+d] && w[(r+1)*D+d+1]) begin
               w[r*D+d] = 1'b0; w[(r+1)*D+d+1] = 1'b0;
               f[DG_OFF + r*(D-1) + d] = 1'b1;
            end
      left = w;
   endfunction

   // Expected-value pipeline fed with what the DUT samples at each rising edge.
   logic          sh_v   [DEPTH];
   logic [NB-1:0] sh_left[DEPTH];
   logic [FW-1:0] sh_fix [DEPTH];
   logic [FW-1:0] m_f;
   logic [NB-1:0] m_l;

   always @(posedge clk) begin
      model(win_syn, m_f, m_l);
      if (rst) begin
         for (int k = 0; k < DEPTH; k++) sh_v[k] <= 1'b0;
      end else begin
         for (int k = 1; k < DEPTH; k++) begin
            sh_v[k]    <= sh_v[k-1];
            sh_left[k] <= sh_left[k-1];
            sh_fix[k]  <= sh_fix[k-1];
         end
         sh_v[0]    <= win_valid;
         sh_left[0] <= m_l;
         sh_fix[0]  <= m_f;
      end
   end

   bit stream_on = 1'b0;

   always @(negedge clk) begin
      if (stream_on && !rst) begin
         chk(res_valid == sh_v[DEPTH-1], "R2 valid timing", 64'(res_valid), 64'(sh_v[DEPTH-1]));
         if (sh_v[DEPTH-1]) begin
            chk(res_fix[SPW-1:0] == sh_fix[DEPTH-1][SPW-1:0], "R3 same-round field",
                64'(res_fix[SPW-1:0]), 64'(sh_fix[DEPTH-1][SPW-1:0]));
            chk(res_fix[TM_OFF +: TMW] == sh_fix[DEPTH-1][TM_OFF +: TMW], "R4 round-to-round field",
                64'(res_fix[TM_OFF +: TMW]), 64'(sh_fix[DEPTH-1][TM_OFF +: TMW]));
            chk(res_fix[DG_OFF +: DGW] == sh_fix[DEPTH-1][DG_OFF +: DGW], "R5 diagonal field",
                64'(res_fix[DG_OFF +: DGW]), 64'(sh_fix[DEPTH-1][DG_OFF +: DGW]));
            if (sh_left[DEPTH-1] != '0)
               chk(res_complex == 1'b1, "R9 complex flag", 64'(res_complex), 64'd1);
            else
               chk(res_complex == 1'b0 && res_syn == '0, "R10 clean window",
                   64'(res_syn), 64'd0);
            chk(res_syn == sh_left[DEPTH-1], "R11 residual", 64'(res_syn), 64'(sh_left[DEPTH-1]));
         end
      end
   end

   task automatic drive(input logic v, input logic [NB-1:0] s);
      win_valid = v;
      win_syn   = s;
      @(negedge clk);
   endtask

   // One window followed by bubbles; outputs checked on the ninth falling edge.
   task automatic directed(input logic [NB-1:0] s, input logic [FW-1:0] ef, input logic [NB-1:0] er,
                           input logic ec, input string req);
      drive(1'b1, s);
      drive(1'b0, '0);
      repeat (7) @(negedge clk);
      chk(res_valid == 1'b1, {req, " valid"}, 64'(res_valid), 64'd1);
      chk(res_fix == ef, {req, " fix"}, 64'(res_fix), 64'(ef));
      chk(res_syn == er, {req, " residual"}, 64'(res_syn), 64'(er));
      chk(res_complex == ec, {req, " complex"}, 64'(res_complex), 64'(ec));
      @(negedge clk);
      chk(res_valid == 1'b0, {req, " bubble"}, 64'(res_valid), 64'd0);
   endtask

   function automatic logic [NB-1:0] b(input int r, input int d);
      return NB'(1) << (r*D + d);
   endfunction

   function automatic logic [FW-1:0] fb(input int idx);
      return FW'(1) << idx;
   endfunction

   initial begin
      logic [31:0] lfsr;
      @(negedge clk);
      repeat (3) @(negedge clk);
      chk(res_valid == 1'b0, "R1 valid during reset", 64'(res_valid), 64'd0);
      rst = 1'b0;
      @(negedge clk);
      chk(res_valid == 1'b0, "R1 valid after reset", 64'(res_valid), 64'd0);

      // R3: same-round neighbours (1,3)-(1,4)
      directed(b(1,3) | b(1,4), fb(1*(D-1)+3), '0, 1'b0, "R3");
      // R4: same check (5) in rounds 0 and 1
      directed(b(0,5) | b(1,5), fb(TM_OFF + 0*D + 5), '0, 1'b0, "R4");
      // R5: diagonal (1,2)-(2,3)
      directed(b(1,2) | b(2,3), fb(DG_OFF + 1*(D-1) + 2), '0, 1'b0, "R5");
      // R6: (0,0) can pair sideways or upward; same-round wins, (1,0) left
      directed(b(0,0) | b(0,1) | b(1,0), fb(0), b(1,0), 1'b1, "R6");
      // R7: three in a row in round 2; lowest pair wins
      directed(b(2,0) | b(2,1) | b(2,2), fb(2*(D-1)), b(2,2), 1'b1, "R7");
      // R8: four in a row form two disjoint pairs
      directed(b(0,0) | b(0,1) | b(0,2) | b(0,3), fb(0) | fb(2), '0, 1'b0, "R8");
      // R8: (0,1) used sideways cannot also pair with (1,1)
      directed(b(0,1) | b(0,2) | b(1,1), fb(1), b(1,1), 1'b1, "R8");
      // R9: lone flip
      directed(b(2,7), '0, b(2,7), 1'b1, "R9");
      // R10: empty window
      directed('0, '0, '0, 1'b0, "R10");
      // R11: non-adjacent pair stays as residual
      directed(b(0,0) | b(2,2), '0, b(0,0) | b(2,2), 1'b1, "R11");

      stream_on = 1'b1;
      // Every single-flip window, back to back
      for (int i = 0; i < NB; i++) drive(1'b1, NB'(1) << i);
      // Every two-flip window, bubble every seventh slot
      for (int i = 0; i < NB; i++)
         for (int j = i + 1; j < NB; j++) begin
            drive(1'b1, (NB'(1) << i) | (NB'(1) << j));
            if (((i + j) % 7) == 0) drive(1'b0, '1);
         end
      // Pseudo-random dense and sparse windows
      lfsr = 32'hACE1_2468;
      for (int n = 0; n < 3000; n++) begin
         logic [31:0] a;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         a    = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         drive(lfsr[3:0] != 4'd0, (n % 2 == 0) ? a[NB-1:0] : (a[NB-1:0] & lfsr[NB-1:0]));
      end
      // R1: reset in mid-stream drops the windows in flight
      for (int n = 0; n < 4; n++) drive(1'b1, b(0,0) | b(0,1));
      rst = 1'b1;
      drive(1'b0, '0);
      rst = 1'b0;
      for (int n = 0; n < DEPTH + 2; n++) begin
         chk(res_valid == 1'b0, "R1 flushed by reset", 64'(res_valid), 64'd0);
         drive(1'b0, '0);
      end
      drive(1'b1, b(1,6) | b(1,7));
      repeat (DEPTH + 2) drive(1'b0, '0);
      stream_on = 1'b0;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule